// File: doc/BRIEF.md
# Accumulator Execute Stage with Zero-Skip

This block is the execute stage of a small 8-bit accumulator processor. It holds a working register W, a zero flag Z, a 128-byte data register file, a 15-bit program counter and a 4-bit latch that supplies the upper program-counter bits on a jump. Each cycle it may accept one decoded operation. It computes the result, sends it to W or back to the addressed register, updates Z where the operation calls for it, and moves the program counter.

Two operations count a register down or up and cancel the following instruction when the count reaches zero. The jump replaces the low eleven program-counter bits with an immediate and the upper four with the latch. When a skip or a jump takes effect, the block raises a flush output for one cycle. Whatever operation arrives in that slot is dropped, so it has no effect on any state.

A read-only peek port returns any register file entry combinationally. It lets a neighbour, or a bench, observe the register file.

Top module: `acc_exec_unit`

## Requirements
- R1: While rst_n is low, W, Z, the program counter and the upper-bit latch are held at zero, every register file entry reads zero and flush_out is low.
- R2: The register operand is addressed by the 7-bit op_reg field (0 to 127). For operations that produce data, op_dest = 0 sends the result to W and op_dest = 1 writes it back into the addressed register, leaving W unchanged.
- R3: Code 1 (decrement and skip) produces register minus one, modulo 256. A zero result cancels the next slot and advances the PC by two. A non-zero result advances the PC by one.
- R4: Code 3 (increment and skip) produces register plus one, modulo 256, so 0xFF gives 0x00 and skips. It uses the same skip and PC rule as R3. Neither skip operation changes Z.
- R5: Code 5 (OR literal) writes W OR op_imm[7:0] into W whatever op_dest is, and writes no register.
- R6: Code 2 (increment, wrapping modulo 256), code 4 (W OR register) and code 5 set Z to 1 exactly when their result is zero.
- R7: Code 6 (jump) loads the PC with {latch, op_imm[10:0]} and flushes the next slot. The latch is loaded from hi_din when hi_we is high, independent of op_valid.
- R8: After a taken skip or a jump, flush_out is high for exactly the next cycle. An operation presented in that cycle changes none of W, Z, the register file or the PC, and raises no further flush.
- R9: Every accepted operation that is neither a jump nor a taken skip advances the PC by one, including the no-op codes 0 and 7. With op_valid low, the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation code (0 no-op, 1 dec-skip, 2 inc, 3 inc-skip, 4 OR reg, 5 OR literal, 6 jump, 7 no-op) |
| op_reg | input | 7 | Register file address |
| op_dest | input | 1 | Result destination: 0 W, 1 register |
| op_imm | input | 11 | Jump target low bits; bits 7:0 are the OR literal |
| hi_we | input | 1 | Load the upper-PC latch |
| hi_din | input | 4 | Value for the upper-PC latch |
| peek_addr | input | 7 | Register file peek address |
| peek_data | output | 8 | Register file entry at peek_addr |
| w_out | output | 8 | Working register |
| z_out | output | 1 | Zero flag |
| pc_out | output | 15 | Program counter |
| flush_out | output | 1 | The current slot is cancelled |

## Verification
The assertions assume that op_code, op_reg, op_dest and op_imm are at known values in every cycle that op_valid is high. They also assume the latch is not written in the same cycle as the jump that reads it, because the jump would then use the old latch value. The bench drives every field at a defined value in every cycle, keeps hi_we low except in a dedicated idle cycle, and changes inputs only one nanosecond after the rising edge. Back-to-back operations are issued right after skips and jumps so that the cancelled slot carries a live operation: one that would write, set Z, or skip again.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int PC_W   = 15;
  localparam int IMM_W  = 11;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_DECSKZ = 3'd1,
    OP_INC    = 3'd2,
    OP_INCSKZ = 3'd3,
    OP_ORREG  = 3'd4,
    OP_ORLIT  = 3'd5,
    OP_JUMP   = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  op_e           op,
  input  logic [DW-1:0] w_val,
  input  logic [DW-1:0] f_val,
  input  logic [DW-1:0] lit,
  output logic [DW-1:0] result,
  output logic          res_zero,
  output logic          sets_z,
  output logic          is_skip,
  output logic          makes_data
);
  always_comb begin
    result     = f_val;
    sets_z     = 1'b0;
    is_skip    = 1'b0;
    makes_data = 1'b1;
    case (op)
      OP_DECSKZ: begin result = f_val - 1'b1; is_skip = 1'b1; end
      OP_INCSKZ: begin result = f_val + 1'b1; is_skip = 1'b1; end
      OP_INC:    begin result = f_val + 1'b1; sets_z = 1'b1; end
      OP_ORREG:  begin result = w_val | f_val; sets_z = 1'b1; end
      OP_ORLIT:  begin result = w_val | lit; sets_z = 1'b1; end
      default:   makes_data = 1'b0;
    endcase
    res_zero = (result == '0);
  end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

  // R2: a write lands at its address and is seen through the read port
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && raddr_b == waddr) ##1 (raddr_b == $past(waddr)) |-> (rdata_b == $past(wdata)));
endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
  parameter int PC_W  = 15,
  parameter int IMM_W = 11,
  localparam int HI_W = PC_W - IMM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_we,
  input  logic [HI_W-1:0]  hi_din,
  input  logic             adv1,
  input  logic             adv2,
  input  logic             jump,
  input  logic [IMM_W-1:0] jimm,
  output logic [PC_W-1:0]  pc,
  output logic [HI_W-1:0]  hi
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic [HI_W-1:0] hi_q;
  logic            pc_en;

  always_comb begin
    pc_en = adv1 | adv2 | jump;
    pc_d  = pc_q;
    if (jump)      pc_d = {hi_q, jimm};
    else if (adv2) pc_d = pc_q + PC_W'(2);
    else if (adv1) pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_we) hi_q <= hi_din;
  end

  assign pc = pc_q;
  assign hi = hi_q;

  // R7: jump target built from latch and immediate
  assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> (pc_q == {$past(hi_q), $past(jimm)}));
  // R9: PC holds when nothing advances it
  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv1 || adv2 || jump) |=> $stable(pc_q));
  // R3: a taken skip moves the PC by two
  assert_skip_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv2 && !jump) |=> (pc_q == $past(pc_q) + PC_W'(2)));
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int DEPTH = 128,
  parameter int PCW   = PC_W,
  parameter int IMMW  = IMM_W,
  localparam int AW   = $clog2(DEPTH),
  localparam int HIW  = PCW - IMMW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [AW-1:0]   op_reg,
  input  logic            op_dest,
  input  logic [IMMW-1:0] op_imm,
  input  logic            hi_we,
  input  logic [HIW-1:0]  hi_din,
  input  logic [AW-1:0]   peek_addr,
  output logic [DW-1:0]   peek_data,
  output logic [DW-1:0]   w_out,
  output logic            z_out,
  output logic [PCW-1:0]  pc_out,
  output logic            flush_out
);
  op_e           op;
  logic          issue;
  logic [DW-1:0] w_q, w_d, f_val, result;
  logic          z_q, z_d, w_en, z_en, rf_we;
  logic          flush_q, flush_d;
  logic          res_zero, sets_z, is_skip, makes_data;
  logic          skip_take, jump_take, adv1;
  logic [HIW-1:0] hi_unused;

  assign op    = op_e'(op_code);
  assign issue = op_valid && !flush_q;

  acc_alu #(.DW(DW)) u_alu (
    .op(op), .w_val(w_q), .f_val(f_val), .lit(op_imm[DW-1:0]),
    .result(result), .res_zero(res_zero), .sets_z(sets_z),
    .is_skip(is_skip), .makes_data(makes_data)
  );

  acc_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(op_reg), .wdata(result),
    .raddr_a(op_reg), .rdata_a(f_val), .raddr_b(peek_addr), .rdata_b(peek_data)
  );

  always_comb begin
    w_en      = 1'b0;
    rf_we     = 1'b0;
    w_d       = result;
    z_en      = issue && sets_z;
    z_d       = res_zero;
    skip_take = issue && is_skip && res_zero;
    jump_take = issue && (op == OP_JUMP);
    adv1      = issue && !skip_take && !jump_take;
    flush_d   = skip_take || jump_take;
    if (issue && makes_data) begin
      if (op == OP_ORLIT || !op_dest) w_en  = 1'b1;
      else                            rf_we = 1'b1;
    end
  end

  acc_pc #(.PC_W(PCW), .IMM_W(IMMW)) u_pc (
    .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .hi_din(hi_din),
    .adv1(adv1), .adv2(skip_take), .jump(jump_take), .jimm(op_imm),
    .pc(pc_out), .hi(hi_unused)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    w_q <= '0;
    else if (w_en) w_q <= w_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    z_q <= 1'b0;
    else if (z_en) z_q <= z_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  assign w_out     = w_q;
  assign z_out     = z_q;
  assign flush_out = flush_q;

  // R8: flush lasts one cycle and the cancelled slot is silent
  assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);
  assert_squash_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> ($stable(w_q) && $stable(z_q)));
  // R4: skip operations never touch Z
  assert_skip_keeps_z_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flush_out && (op_code == 3'd1 || op_code == 3'd3)) |=> $stable(z_q));
  // R5: literal OR lands in W regardless of the destination bit
  assert_orlit_to_w_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flush_out && op_code == 3'd5) |=>
      (w_q == ($past(w_q) | $past(op_imm[DW-1:0]))));
  // R2: register destination leaves W alone
  assert_dest_reg_keeps_w_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flush_out && op_dest && op_code != 3'd5) |=> $stable(w_q));
endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [6:0]  op_reg;
  logic        op_dest;
  logic [10:0] op_imm;
  logic        hi_we;
  logic [3:0]  hi_din;
  logic [6:0]  peek_addr;
  logic [7:0]  peek_data, w_out;
  logic        z_out, flush_out;
  logic [14:0] pc_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  acc_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_reg(op_reg), .op_dest(op_dest), .op_imm(op_imm), .hi_we(hi_we),
    .hi_din(hi_din), .peek_addr(peek_addr), .peek_data(peek_data),
    .w_out(w_out), .z_out(z_out), .pc_out(pc_out), .flush_out(flush_out)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [6:0]  rg;
    logic        dst;
    logic [10:0] imm;
    logic [7:0]  ew;
    logic        ez;
    logic [14:0] epc;
    logic        efl;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd5, 7'd0,  1'b0, 11'h005, 8'h05, 1'b0, 15'd1,  1'b0},
    '{3'd4, 7'd3,  1'b1, 11'h000, 8'h05, 1'b0, 15'd2,  1'b0},
    '{3'd5, 7'd0,  1'b0, 11'h000, 8'h05, 1'b0, 15'd3,  1'b0},
    '{3'd1, 7'd3,  1'b1, 11'h000, 8'h05, 1'b0, 15'd4,  1'b0},
    '{3'd2, 7'd10, 1'b0, 11'h000, 8'h01, 1'b0, 15'd5,  1'b0},
    '{3'd5, 7'd0,  1'b0, 11'h0F0, 8'hF1, 1'b0, 15'd6,  1'b0},
    '{3'd4, 7'd10, 1'b1, 11'h000, 8'hF1, 1'b0, 15'd7,  1'b0},
    '{3'd5, 7'd0,  1'b0, 11'h00E, 8'hFF, 1'b0, 15'd8,  1'b0},
    '{3'd4, 7'd20, 1'b1, 11'h000, 8'hFF, 1'b0, 15'd9,  1'b0},
    '{3'd2, 7'd20, 1'b0, 11'h000, 8'h00, 1'b1, 15'd10, 1'b0},
    '{3'd3, 7'd20, 1'b1, 11'h000, 8'h00, 1'b1, 15'd12, 1'b1},
    '{3'd5, 7'd0,  1'b0, 11'h077, 8'h00, 1'b1, 15'd12, 1'b0},
    '{3'd1, 7'd3,  1'b0, 11'h000, 8'h03, 1'b1, 15'd13, 1'b0},
    '{3'd3, 7'd3,  1'b0, 11'h000, 8'h05, 1'b1, 15'd14, 1'b0},
    '{3'd5, 7'd0,  1'b0, 11'h000, 8'h05, 1'b0, 15'd15, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [6:0] r, input logic d,
                       input logic [10:0] i);
    op_valid = 1'b1; op_code = c; op_reg = r; op_dest = d; op_imm = i;
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic state(input string tag, input logic [7:0] ew, input logic ez,
                       input logic [14:0] epc, input logic efl);
    chk({tag, " W"}, 32'(w_out), 32'(ew));
    chk({tag, " Z"}, 32'(z_out), 32'(ez));
    chk({tag, " PC"}, 32'(pc_out), 32'(epc));
    chk({tag, " flush"}, 32'(flush_out), 32'(efl));
  endtask

  task automatic peek(input string tag, input logic [6:0] a, input logic [7:0] e);
    peek_addr = a; #0.1;
    chk(tag, 32'(peek_data), 32'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_reg = '0; op_dest = 1'b0;
    op_imm = '0; hi_we = 1'b0; hi_din = '0; peek_addr = '0;
    repeat (3) @(posedge clk); #1;
    state("R1 reset", 8'h00, 1'b0, 15'd0, 1'b0);
    peek("R1 reset reg", 7'd3, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k].op, VEC[k].rg, VEC[k].dst, VEC[k].imm);
      state($sformatf("R2/R3/R4/R5/R6/R8/R9 vec%0d", k), VEC[k].ew, VEC[k].ez,
            VEC[k].epc, VEC[k].efl);
    end

    peek("R2 dest reg write f3", 7'd3, 8'h04);
    peek("R2 OR into f10", 7'd10, 8'hF1);
    peek("R4 wrap FF to 00 f20", 7'd20, 8'h00);

    // R5: literal OR with destination bit set still goes to W
    issue(3'd5, 7'd0, 1'b1, 11'h080);
    state("R5 literal dest ignored", 8'h85, 1'b0, 15'd16, 1'b0);
    peek("R5 reg untouched", 7'd0, 8'h00);

    // R9: idle cycle with latch write, PC holds
    hi_we = 1'b1; hi_din = 4'hA;
    @(posedge clk); #1;
    hi_we = 1'b0;
    chk("R9 idle PC hold", 32'(pc_out), 32'd16);

    // R7: jump
    issue(3'd6, 7'd0, 1'b0, 11'h123);
    state("R7 jump", 8'h85, 1'b0, 15'h5123, 1'b1);

    // R8: squashed register write
    issue(3'd4, 7'd3, 1'b1, 11'h000);
    state("R8 squash after jump", 8'h85, 1'b0, 15'h5123, 1'b0);
    peek("R8 squashed write", 7'd3, 8'h04);

    // R3: decrement of zero wraps to FF, no skip
    issue(3'd1, 7'd20, 1'b1, 11'h000);
    state("R3 dec wrap no skip", 8'h85, 1'b0, 15'h5124, 1'b0);
    peek("R3 dec wrap value", 7'd20, 8'hFF);

    // R4: increment-skip of FF into W, Z held at 0
    issue(3'd3, 7'd20, 1'b0, 11'h000);
    state("R4 inc skip", 8'h00, 1'b0, 15'h5126, 1'b1);

    // R8: squashed skip op neither writes nor flushes again
    issue(3'd3, 7'd20, 1'b1, 11'h000);
    state("R8 squashed skip", 8'h00, 1'b0, 15'h5126, 1'b0);
    peek("R8 squashed skip reg", 7'd20, 8'hFF);

    // R9: reserved code acts as no-op
    issue(3'd7, 7'd20, 1'b1, 11'h000);
    state("R9 code7 no-op", 8'h00, 1'b0, 15'h5127, 1'b0);

    // R6: plain increment wraps and sets Z
    issue(3'd2, 7'd20, 1'b1, 11'h000);
    state("R6 inc wrap Z", 8'h00, 1'b1, 15'h5128, 1'b0);
    peek("R6 inc wrap reg", 7'd20, 8'h00);

    // R1: reset in mid-run
    rst_n = 1'b0; #1;
    state("R1 mid reset", 8'h00, 1'b0, 15'd0, 1'b0);
    peek("R1 mid reset reg", 7'd10, 8'h00);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    issue(3'd6, 7'd0, 1'b0, 11'h007);
    chk("R1 latch cleared", 32'(pc_out), 32'h0007);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule